// File: doc/BRIEF.md
# Transmit Channel-Status and User-Bit Composer

This block supplies the channel-status (C) and user (U) bit for every subframe of an outgoing digital-audio stream built on 192-frame blocks. A framer presents the current frame number, the subframe number and a block-start strobe once per subframe cycle. One clock later the block returns the C and U bits for that position. The framer does the biphase coding and builds the preambles.

The C bit can come from a 192-bit transmit status word that software loads one byte at a time, or from an auxiliary serial stream. A serial C pin can be ORed onto it. When the word marks consumer use, the audio-channel field is rewritten per subframe. When the word marks professional use, the block can replace the last byte with a CRC. A status word recovered by a receiver can be copied into the transmit word on request. The copy takes effect at the next block boundary and not before. The U bit comes from a serial pin, the auxiliary stream, a constant zero, or the receiver's recovered U bit. The receiver path is used only while the receiver reports lock.

Top module: `cs_tx_composer`

## Requirements
- R1: `c_out` and `u_out` register the bits for the `frame_idx`/`sub_idx` values presented at a rising edge, and they appear after that edge. While `rst_n` is low, `c_out`, `u_out` and `xfer_busy` are 0 and the status word is all zeros.
- R2: With `cs_src`=1, `ser_mode`=1 and none of the field rules of R6/R7 applying, C equals bit `frame_idx` of the effective status word. Frame 0 carries bit 0.
- R3: A cycle with `wr_en`=1 writes `wr_data` bit k into status bit 8*`wr_idx`+k, and the new value takes effect from the next cycle. The write is ignored when `xfer_busy`=1 or `wr_idx`>=24.
- R4: With `ser_mode`=0 and `aes3_mode`=0, C is the selected source bit ORed with `ser_c`.
- R5: With `aes3_mode`=1, `ser_c` and `ser_u` have no effect and U equals `aux_u`. `cs_src`=0 makes C equal `aux_c` (also outside that mode), while `cs_src`=1 selects the status word.
- R6: Status bit 0 = 0 (consumer) with `cs_src`=1 overrides frames 20..23. With `stereo`=1 they carry 1,0,0,0 in subframe 0 and 0,1,0,0 in subframe 1. With `stereo`=0 they carry 0,0,0,0 in both subframes.
- R7: Status bit 0 = 1 (professional) with `crc_en`=1 and `cs_src`=1 makes frames 184..191 carry a CRC. The CRC shift register starts at 0xFF. Status bits 0..183 are fed in order, each with feedback = crc[7] XOR bit, a left shift, and XOR with 0x1D when the feedback is 1. Frame 184+k carries crc[k].
- R8: With `crc_en`=0 or in consumer mode, frames 184..191 carry the stored word bits unchanged.
- R9: A rising edge on `xfer_req` (0 the previous cycle, 1 now) while `xfer_busy`=0 captures `rx_status` and sets `xfer_busy` from the next cycle. At the next `blk_start` cycle after that, the captured word governs C from that cycle on, becomes the stored word, and `xfer_busy` returns to 0. A rising edge while busy is ignored.
- R10: With `aes3_mode`=0 and `ser_mode`=0, U equals `ser_u`.
- R11: With `aes3_mode`=0 and `ser_mode`=1, U equals `rx_u` only when `sync_mode`, `u_loop` and `pll_lock` are all 1. Otherwise U is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Strobe marking frame 0, subframe 0 of a block |
| frame_idx | input | 8 | Frame number within the block (0..191) |
| sub_idx | input | 1 | Subframe number (0 or 1) |
| wr_en | input | 1 | Byte write strobe for the status word |
| wr_idx | input | 5 | Byte index of the write (0..23) |
| wr_data | input | 8 | Byte value to write |
| xfer_req | input | 1 | Receive-to-transmit copy request (edge sensitive) |
| rx_status | input | 192 | Status word recovered by the receiver |
| cs_src | input | 1 | C source: 0 auxiliary stream, 1 status word |
| ser_mode | input | 1 | 0: serial pins active; 1: pins unused |
| aes3_mode | input | 1 | Auxiliary framing mode; serial pins ignored |
| stereo | input | 1 | Consumer audio-channel field control |
| crc_en | input | 1 | Professional CRC enable |
| sync_mode | input | 1 | Synchronous operation flag for U loop |
| u_loop | input | 1 | Loop recovered U bits back to the output |
| pll_lock | input | 1 | Receiver lock indication |
| ser_c | input | 1 | Serial C input |
| ser_u | input | 1 | Serial U input |
| aux_c | input | 1 | C bit from auxiliary stream |
| aux_u | input | 1 | U bit from auxiliary stream |
| rx_u | input | 1 | Recovered U bit from receiver |
| c_out | output | 1 | Composed channel-status bit |
| u_out | output | 1 | Composed user bit |
| xfer_busy | output | 1 | Copy pending; clears at the committing block start |

## Verification
Every C and U result is due exactly one clock after its frame position is presented. `xfer_busy` changes on the edge that sees the request or the committing block start. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs, and the outputs are compared on the next falling edge, so each comparison falls in the cycle its result is due. A copy requested in mid-block must leave the rest of that block unchanged and switch at frame 0 of the next block. The per-cycle comparison catches a switch that comes one position early or late.

// File: rtl/cs_tx_pkg.sv
package cs_tx_pkg;
    localparam int CS_FRAMES   = 192;
    localparam int CS_BYTE_W   = 8;
    localparam logic [7:0] CS_CRC_POLY = 8'h1D;
    localparam logic [7:0] CS_CRC_INIT = 8'hFF;
    localparam int CS_CH_FIELD = 20;
endpackage

// File: rtl/cs_crc8.sv
module cs_crc8
    import cs_tx_pkg::*;
#(
    parameter int FRAMES = CS_FRAMES,
    localparam int CRC_POS = FRAMES - CS_BYTE_W
) (
    input  logic [FRAMES-1:0]    word,
    output logic [CS_BYTE_W-1:0] crc
);
    logic [CS_BYTE_W-1:0] acc;
    logic                 fb;

    always_comb begin
        acc = CS_CRC_INIT;
        fb  = 1'b0;
        for (int i = 0; i < CRC_POS; i++) begin
            fb  = acc[CS_BYTE_W-1] ^ word[i];
            acc = {acc[CS_BYTE_W-2:0], 1'b0};
            if (fb) acc = acc ^ CS_CRC_POLY;
        end
        crc = acc;
    end
endmodule

// File: rtl/cs_bit_select.sv
module cs_bit_select
    import cs_tx_pkg::*;
#(
    parameter int FRAMES = CS_FRAMES,
    localparam int IDX_W   = $clog2(FRAMES),
    localparam int CRC_POS = FRAMES - CS_BYTE_W
) (
    input  logic [FRAMES-1:0]    word,
    input  logic [CS_BYTE_W-1:0] crc,
    input  logic [IDX_W-1:0]     frame_idx,
    input  logic                 sub_idx,
    input  logic                 cs_src,
    input  logic                 ser_mode,
    input  logic                 aes3_mode,
    input  logic                 stereo,
    input  logic                 crc_en,
    input  logic                 sync_mode,
    input  logic                 u_loop,
    input  logic                 pll_lock,
    input  logic                 ser_c,
    input  logic                 ser_u,
    input  logic                 aux_c,
    input  logic                 aux_u,
    input  logic                 rx_u,
    output logic                 c_sel,
    output logic                 u_sel
);
    logic pro, in_range, in_field, in_crc, word_bit, pins_live;

    always_comb begin
        pro       = word[0];
        in_range  = frame_idx < IDX_W'(FRAMES);
        in_field  = (frame_idx >= IDX_W'(CS_CH_FIELD)) && (frame_idx <= IDX_W'(CS_CH_FIELD + 3));
        in_crc    = frame_idx >= IDX_W'(CRC_POS);
        pins_live = !aes3_mode && !ser_mode;

        if (!in_range)
            word_bit = 1'b0;
        else if (!pro && in_field)
            word_bit = stereo && ((!sub_idx && frame_idx == IDX_W'(CS_CH_FIELD)) ||
                                  ( sub_idx && frame_idx == IDX_W'(CS_CH_FIELD + 1)));
        else if (pro && crc_en && in_crc)
            word_bit = crc[frame_idx[2:0]];
        else
            word_bit = word[frame_idx];

        c_sel = (cs_src ? word_bit : aux_c) | (pins_live & ser_c);

        if (aes3_mode)
            u_sel = aux_u;
        else if (!ser_mode)
            u_sel = ser_u;
        else
            u_sel = sync_mode && u_loop && pll_lock && rx_u;
    end
endmodule

// File: rtl/cs_tx_composer.sv
module cs_tx_composer
    import cs_tx_pkg::*;
#(
    parameter int FRAMES = CS_FRAMES,
    localparam int IDX_W      = $clog2(FRAMES),
    localparam int NBYTES     = FRAMES / CS_BYTE_W,
    localparam int BYTE_IDX_W = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blk_start,
    input  logic [IDX_W-1:0]      frame_idx,
    input  logic                  sub_idx,
    input  logic                  wr_en,
    input  logic [BYTE_IDX_W-1:0] wr_idx,
    input  logic [CS_BYTE_W-1:0]  wr_data,
    input  logic                  xfer_req,
    input  logic [FRAMES-1:0]     rx_status,
    input  logic                  cs_src,
    input  logic                  ser_mode,
    input  logic                  aes3_mode,
    input  logic                  stereo,
    input  logic                  crc_en,
    input  logic                  sync_mode,
    input  logic                  u_loop,
    input  logic                  pll_lock,
    input  logic                  ser_c,
    input  logic                  ser_u,
    input  logic                  aux_c,
    input  logic                  aux_u,
    input  logic                  rx_u,
    output logic                  c_out,
    output logic                  u_out,
    output logic                  xfer_busy
);
    typedef struct packed {
        logic [FRAMES-1:0] active;
        logic [FRAMES-1:0] pending;
        logic              busy;
        logic              req_prev;
        logic              c;
        logic              u;
    } st_t;

    st_t st_d, st_q;

    logic [FRAMES-1:0]    eff_word;
    logic [CS_BYTE_W-1:0] crc_val;
    logic                 commit, req_rise, c_sel, u_sel;

    assign commit   = blk_start && st_q.busy;
    assign req_rise = xfer_req && !st_q.req_prev;
    assign eff_word = commit ? st_q.pending : st_q.active;

    cs_crc8 #(.FRAMES(FRAMES)) u_crc (
        .word (eff_word),
        .crc  (crc_val)
    );

    cs_bit_select #(.FRAMES(FRAMES)) u_sel_blk (
        .word      (eff_word),
        .crc       (crc_val),
        .frame_idx (frame_idx),
        .sub_idx   (sub_idx),
        .cs_src    (cs_src),
        .ser_mode  (ser_mode),
        .aes3_mode (aes3_mode),
        .stereo    (stereo),
        .crc_en    (crc_en),
        .sync_mode (sync_mode),
        .u_loop    (u_loop),
        .pll_lock  (pll_lock),
        .ser_c     (ser_c),
        .ser_u     (ser_u),
        .aux_c     (aux_c),
        .aux_u     (aux_u),
        .rx_u      (rx_u),
        .c_sel     (c_sel),
        .u_sel     (u_sel)
    );

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = xfer_req;
        st_d.c        = c_sel;
        st_d.u        = u_sel;
        if (commit) begin
            st_d.active = st_q.pending;
            st_d.busy   = 1'b0;
        end else if (wr_en && !st_q.busy && wr_idx < BYTE_IDX_W'(NBYTES)) begin
            st_d.active[CS_BYTE_W*int'(wr_idx) +: CS_BYTE_W] = wr_data;
        end
        if (req_rise && !st_q.busy) begin
            st_d.pending = rx_status;
            st_d.busy    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c_out     = st_q.c;
    assign u_out     = st_q.u;
    assign xfer_busy = st_q.busy;

    // R9: an accepted request raises the busy flag on the next edge
    a_r9_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !st_q.req_prev && !xfer_busy) |=> xfer_busy);
    // R9: busy stays up until a block start
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !blk_start) |=> xfer_busy);
    // R9: the committing block start clears busy
    a_r9_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && blk_start) |=> !xfer_busy);
    // R3: stored word frozen while a copy is pending
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !blk_start) |=> $stable(st_q.active));
    // R11: loop path without full enable yields zero
    a_r11_u_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!aes3_mode && ser_mode && !(sync_mode && u_loop && pll_lock)) |=> !u_out);
    // R5: auxiliary framing drives U from the auxiliary stream
    a_r5_aux_u: assert property (@(posedge clk) disable iff (!rst_n)
        aes3_mode |=> (u_out == $past(aux_u)));
endmodule

// File: tb/cs_tx_composer_test.sv
module cs_tx_composer_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_start = 1'b0;
    logic [7:0]   frame_idx = '0;
    logic         sub_idx = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_idx = '0;
    logic [7:0]   wr_data = '0;
    logic         xfer_req = 1'b0;
    logic [191:0] rx_status = '0;
    logic cs_src = 1'b1, ser_mode = 1'b1, aes3_mode = 1'b0, stereo = 1'b0, crc_en = 1'b0;
    logic sync_mode = 1'b1, u_loop = 1'b0, pll_lock = 1'b1;
    logic ser_c = 1'b0, ser_u = 1'b0, aux_c = 1'b0, aux_u = 1'b0, rx_u = 1'b0;
    logic c_out, u_out, xfer_busy;

    int checks = 0, failures = 0;
    bit chk_on = 1'b0, done = 1'b0, lock_rand = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    cs_tx_composer uut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .frame_idx(frame_idx),
        .sub_idx(sub_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .xfer_req(xfer_req), .rx_status(rx_status), .cs_src(cs_src),
        .ser_mode(ser_mode), .aes3_mode(aes3_mode), .stereo(stereo), .crc_en(crc_en),
        .sync_mode(sync_mode), .u_loop(u_loop), .pll_lock(pll_lock), .ser_c(ser_c),
        .ser_u(ser_u), .aux_c(aux_c), .aux_u(aux_u), .rx_u(rx_u),
        .c_out(c_out), .u_out(u_out), .xfer_busy(xfer_busy)
    );

    // behavioural reference
    logic [191:0] m_active, m_pending, m_w;
    bit m_busy, m_prev, e_c, e_u, e_busy;
    string c_tag, u_tag;

    function automatic logic [7:0] ref_crc(input logic [191:0] w);
        logic [7:0] r = 8'hFF;
        for (int i = 0; i < 184; i++) begin
            logic f = r[7] ^ w[i];
            r = {r[6:0], 1'b0};
            if (f) r = r ^ 8'h1D;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = '0; m_pending = '0; m_busy = 0; m_prev = 0;
            e_c = 0; e_u = 0; e_busy = 0;
        end else begin
            int f;
            logic [7:0] cr;
            f = int'(frame_idx);
            m_w = (blk_start && m_busy) ? m_pending : m_active;
            cr = ref_crc(m_w);
            c_tag = "R2";
            if (!cs_src) begin e_c = aux_c; c_tag = "R5"; end
            else if (!m_w[0] && f >= 20 && f <= 23) begin
                e_c = stereo && ((sub_idx == 0 && f == 20) || (sub_idx == 1 && f == 21));
                c_tag = "R6";
            end else if (m_w[0] && crc_en && f >= 184) begin
                e_c = cr[f-184]; c_tag = "R7";
            end else begin
                e_c = m_w[f];
                if (f >= 184) c_tag = "R8";
            end
            if (!aes3_mode && !ser_mode) begin e_c = e_c | ser_c; c_tag = {c_tag, "/R4"}; end
            if (aes3_mode) begin e_u = aux_u; u_tag = "R5"; end
            else if (!ser_mode) begin e_u = ser_u; u_tag = "R10"; end
            else begin e_u = sync_mode && u_loop && pll_lock && rx_u; u_tag = "R11"; end

            if (blk_start && m_busy) begin m_active = m_pending; m_busy = 0; end
            else if (wr_en && !m_busy && wr_idx < 24) m_active[8*int'(wr_idx) +: 8] = wr_data;
            if (xfer_req && !m_prev && !m_busy) begin m_pending = rx_status; m_busy = 1; end
            m_prev = xfer_req;
            e_busy = m_busy;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b (frame %0d sub %0d)", req, act, exp, frame_idx, sub_idx);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check({phase, "/", c_tag, " c_out"}, c_out, e_c);
            check({phase, "/", u_tag, " u_out"}, u_out, e_u);
            check({phase, "/R9 xfer_busy"}, xfer_busy, e_busy);
        end
    end

    task automatic drive(input int f, input int s);
        @(negedge clk);
        frame_idx = 8'(f); sub_idx = s[0]; blk_start = (f == 0 && s == 0);
        ser_c = 1'($urandom); ser_u = 1'($urandom); aux_c = 1'($urandom);
        aux_u = 1'($urandom); rx_u = 1'($urandom);
        if (lock_rand) pll_lock = 1'($urandom);
    endtask

    task automatic load_word(input logic [191:0] w);
        for (int b = 0; b < 24; b++) begin
            drive(b, 1);
            wr_en = 1; wr_idx = 5'(b); wr_data = w[8*b +: 8];
        end
        drive(30, 1);
        wr_en = 0;
    endtask

    task automatic run_block(input bit do_xfer);
        for (int f = 0; f < 192; f++) begin
            for (int s = 0; s < 2; s++) begin
                drive(f, s);
                wr_en = 0; xfer_req = 0;
                if (do_xfer && s == 0 && (f == 100 || f == 160)) xfer_req = 1;
                if (do_xfer && f == 150 && s == 0) begin wr_en = 1; wr_idx = 0; wr_data = 8'hA5; end
            end
        end
    endtask

    function automatic logic [191:0] rnd_word(input bit pro);
        logic [191:0] w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        w[0] = pro;
        return w;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset c_out", c_out, 1'b0);
        check("R1 reset u_out", u_out, 1'b0);
        check("R1 reset xfer_busy", xfer_busy, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;

        phase = "R3"; stereo = 1; load_word(rnd_word(0));
        phase = "R6"; run_block(0);
        phase = "R4"; stereo = 0; ser_mode = 0; run_block(0);
        phase = "R7"; ser_mode = 1; load_word(rnd_word(1)); crc_en = 1; run_block(0);
        phase = "R8"; crc_en = 0; run_block(0);
        phase = "R5"; aes3_mode = 1; cs_src = 0; run_block(0);
        cs_src = 1; run_block(0);
        phase = "R11"; aes3_mode = 0; u_loop = 1; lock_rand = 1; run_block(0);
        sync_mode = 0; run_block(0);
        sync_mode = 1; lock_rand = 0; pll_lock = 1;
        phase = "R9"; crc_en = 1; rx_status = rnd_word(1);
        run_block(1);
        rx_status = rnd_word(0);
        run_block(0);
        phase = "R9"; stereo = 1; run_block(1);
        run_block(0);
        drive(5, 0);
        @(negedge clk);
        chk_on = 0;
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule